// File: doc/BRIEF.md
# Charge-Transfer Touch Acquisition Sequencer

This block sequences one capacitive touch measurement made of repeated charge-transfer cycles. After a one-clock start pulse it steps through a fixed series of phases in every cycle. First it charges the sense electrode. It then waits in a short guard gap and, if enabled, runs an extend-charge phase. Next it transfers charge to the sampling capacitor, waits in a second guard gap and compares. A final guard gap closes the cycle, and the next cycle follows. The block counts cycles until the synchronized comparator input reports that the sample voltage is above threshold, or until a programmed maximum cycle count is reached. It then returns to idle, latches the cycle count, pulses a done flag and reports whether the limit caused the stop.

All logic runs on the system clock. Two separate enable-tick dividers time the phases. The divider ratios are selected as powers of two from 1 to 128. One divider times the charge and transfer phases. The other times the extend-charge phase, whose length follows a rising and falling pattern from cycle to cycle to spread the emission spectrum. Each divider restarts whenever its phase is entered, so phase lengths are exact multiples of the system clock. The analog switches are modelled as three drive outputs and the comparator as a plain input. Configuration inputs must stay stable while `busy_o` is high. There is no data stream, so no pin uses a valid/ready handshake.

Top module: `cts_sequencer`

## Requirements
- R1: After reset all drive outputs, `busy_o`, `done_o` and `maxerr_o` are 0 and `count_o` is 0. `busy_o` is 1 from the clock after an accepted start until the clock in which `done_o` pulses.
- R2: The three guard gaps each last exactly 2 clocks. At most one of `chg_drv_o`, `ext_drv_o` and `xfer_drv_o` is high in any clock. In each cycle the order is charge, gap, extend (optional), transfer, gap, compare (1 clock), and then either a gap of 2 clocks before the next cycle or idle.
- R3: The charge phase lasts (`chg_len_i`+1)·2^`ct_div_i` clocks and the transfer phase lasts (`xfer_len_i`+1)·2^`ct_div_i` clocks. Both lengths are the same in every cycle.
- R4: The extend phase lasts L·2^`ec_div_i` clocks, timed only by `ec_div_i` and independent of `ct_div_i`.
- R5: For cycle n (first cycle n=1) with E=`ec_max_i`, let p=(n-1) mod (2E+2). Then L=p when p≤E+1, and L=2E+2-p otherwise. This gives 0, 1, …, E+1, E, …, 0, 1, ….
- R6: The extend phase is skipped entirely when `ec_en_i` is 0 or L is 0.
- R7: `vs_above_i` passes through two synchronizing flops and is acted on only in the compare clock. When it is seen high, the block goes idle, pulses `done_o` for one clock and loads `count_o` with the cycle number. `count_o` holds between completions.
- R8: The acquisition also ends after the compare of cycle n when n ≥ `max_cyc_i`, so a value of 0 acts as 1. `maxerr_o` is then set, unless the comparator ended the same cycle. `maxerr_o` is cleared by the next accepted start.
- R9: A pulse on `vs_above_i` that is not seen in a compare clock has no effect.
- R10: `start_i` is ignored while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-clock start pulse |
| ct_div_i | input | DIV_W | log2 of the charge/transfer tick divider |
| ec_div_i | input | DIV_W | log2 of the extend tick divider |
| chg_len_i | input | LEN_W | Charge phase length minus one, in ticks |
| xfer_len_i | input | LEN_W | Transfer phase length minus one, in ticks |
| ec_en_i | input | 1 | Extend-charge phase enable |
| ec_max_i | input | ECM_W | Extend profile bound E |
| max_cyc_i | input | CNT_W | Maximum cycle count |
| vs_above_i | input | 1 | Asynchronous comparator result |
| chg_drv_o | output | 1 | Charge switch drive |
| ext_drv_o | output | 1 | Extend-charge switch drive |
| xfer_drv_o | output | 1 | Transfer switch drive |
| busy_o | output | 1 | Acquisition in progress |
| done_o | output | 1 | One-clock completion pulse |
| maxerr_o | output | 1 | Last acquisition stopped on cycle limit |
| count_o | output | CNT_W | Cycle count of last acquisition |

## Verification
The bench uses the default widths: 3-bit divider selects, 4-bit phase lengths, a 7-bit extend bound and an 8-bit cycle counter. These defaults reach divider ratios from 1 up to 128 and profile bounds of 0, 1, 2 and 5. A 14-cycle run with bound 5 covers more than one full 12-cycle profile period, including the fall to zero and the rise that follows it. Further runs reach a maximum count of 0, the comparator and the limit ending the same cycle, a comparator pulse outside compare, and a start pulse during a busy acquisition.

// File: rtl/cts_pkg.sv
package cts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHG,
    ST_GAP1,
    ST_EXT,
    ST_XFER,
    ST_GAP2,
    ST_CMP,
    ST_GAP3
  } cts_state_e;
endpackage

// File: rtl/cts_tick_div.sv
module cts_tick_div #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CW = (1 << SEL_W) - 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit  = CW'((1 << sel_i) - 1);
  assign tick_o = !clr_i && (cnt == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt <= '0;
    else if (clr_i)   cnt <= '0;
    else if (tick_o)  cnt <= '0;
    else              cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/cts_ec_profile.sv
module cts_ec_profile #(
  parameter int ECM_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             advance_i,
  input  logic [ECM_W-1:0] bound_i,
  output logic [ECM_W:0]   len_o
);
  localparam int EL_W = ECM_W + 1;

  logic          rising;
  logic [EL_W-1:0] peak;

  assign peak = EL_W'(bound_i) + EL_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_o  <= '0;
      rising <= 1'b1;
    end else if (restart_i) begin
      len_o  <= '0;
      rising <= 1'b1;
    end else if (advance_i) begin
      if (rising) begin
        if (len_o == peak) begin
          len_o  <= len_o - EL_W'(1);
          rising <= 1'b0;
        end else begin
          len_o <= len_o + EL_W'(1);
        end
      end else begin
        if (len_o == '0) begin
          len_o  <= EL_W'(1);
          rising <= 1'b1;
        end else begin
          len_o <= len_o - EL_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cts_sequencer.sv
module cts_sequencer
  import cts_pkg::*;
#(
  parameter int DIV_W = 3,
  parameter int LEN_W = 4,
  parameter int ECM_W = 7,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] ct_div_i,
  input  logic [DIV_W-1:0] ec_div_i,
  input  logic [LEN_W-1:0] chg_len_i,
  input  logic [LEN_W-1:0] xfer_len_i,
  input  logic             ec_en_i,
  input  logic [ECM_W-1:0] ec_max_i,
  input  logic [CNT_W-1:0] max_cyc_i,
  input  logic             vs_above_i,
  output logic             chg_drv_o,
  output logic             ext_drv_o,
  output logic             xfer_drv_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             maxerr_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int EL_W = ECM_W + 1;
  localparam int PH_W = (EL_W > LEN_W) ? EL_W : LEN_W;

  cts_state_e      st, st_n;
  logic [PH_W-1:0] ph_cnt;
  logic [CNT_W-1:0] cyc;
  logic [EL_W-1:0] ec_len;
  logic vs_s1, vs_s2;
  logic ct_tick, ec_tick, ct_clr, ec_clr;
  logic step, last, term;
  logic prof_restart, prof_adv;

  assign ct_clr = !(st == ST_CHG || st == ST_XFER);
  assign ec_clr = (st != ST_EXT);

  cts_tick_div #(.SEL_W(DIV_W)) u_ct_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(ct_clr), .sel_i(ct_div_i), .tick_o(ct_tick)
  );

  cts_tick_div #(.SEL_W(DIV_W)) u_ec_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(ec_clr), .sel_i(ec_div_i), .tick_o(ec_tick)
  );

  assign prof_restart = (st == ST_IDLE) && start_i;
  assign prof_adv     = (st == ST_GAP3) && last;

  cts_ec_profile #(.ECM_W(ECM_W)) u_prof (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(prof_restart),
    .advance_i(prof_adv),
    .bound_i  (ec_max_i),
    .len_o    (ec_len)
  );

  assign term = vs_s2 || (cyc >= max_cyc_i);

  always_comb begin
    step = 1'b0;
    last = 1'b0;
    st_n = st;
    unique case (st)
      ST_IDLE: begin
        last = start_i;
        st_n = ST_CHG;
      end
      ST_CHG: begin
        step = ct_tick;
        last = ct_tick && (ph_cnt == PH_W'(chg_len_i));
        st_n = ST_GAP1;
      end
      ST_GAP1: begin
        step = 1'b1;
        last = (ph_cnt == PH_W'(1));
        st_n = (ec_en_i && ec_len != '0) ? ST_EXT : ST_XFER;
      end
      ST_EXT: begin
        step = ec_tick;
        last = ec_tick && ((ph_cnt + PH_W'(1)) == PH_W'(ec_len));
        st_n = ST_XFER;
      end
      ST_XFER: begin
        step = ct_tick;
        last = ct_tick && (ph_cnt == PH_W'(xfer_len_i));
        st_n = ST_GAP2;
      end
      ST_GAP2: begin
        step = 1'b1;
        last = (ph_cnt == PH_W'(1));
        st_n = ST_CMP;
      end
      ST_CMP: begin
        last = 1'b1;
        st_n = term ? ST_IDLE : ST_GAP3;
      end
      ST_GAP3: begin
        step = 1'b1;
        last = (ph_cnt == PH_W'(1));
        st_n = ST_CHG;
      end
      default: begin
        last = 1'b1;
        st_n = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_IDLE;
      ph_cnt   <= '0;
      cyc      <= '0;
      vs_s1    <= 1'b0;
      vs_s2    <= 1'b0;
      done_o   <= 1'b0;
      maxerr_o <= 1'b0;
      count_o  <= '0;
    end else begin
      vs_s1  <= vs_above_i;
      vs_s2  <= vs_s1;
      done_o <= 1'b0;
      if (last) begin
        st     <= st_n;
        ph_cnt <= '0;
      end else if (step) begin
        ph_cnt <= ph_cnt + PH_W'(1);
      end
      if (prof_restart) begin
        cyc      <= CNT_W'(1);
        maxerr_o <= 1'b0;
      end
      if (prof_adv) cyc <= cyc + CNT_W'(1);
      if (st == ST_CMP && term) begin
        done_o   <= 1'b1;
        count_o  <= cyc;
        maxerr_o <= !vs_s2;
      end
    end
  end

  assign chg_drv_o  = (st == ST_CHG);
  assign ext_drv_o  = (st == ST_EXT);
  assign xfer_drv_o = (st == ST_XFER);
  assign busy_o     = (st != ST_IDLE);
endmodule

// File: rtl/cts_seq_chk.sv
module cts_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chg_drv_o,
  input logic             ext_drv_o,
  input logic             xfer_drv_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             maxerr_o,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] max_cyc_i
);
  p_one_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({chg_drv_o, ext_drv_o, xfer_drv_o}));

  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_end_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_count_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(count_o));

  p_limit_reached_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && maxerr_o) |-> (count_o >= max_cyc_i));

  p_drive_needs_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_drv_o || ext_drv_o || xfer_drv_o) |-> busy_o);
endmodule

bind cts_sequencer cts_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .chg_drv_o (chg_drv_o),
  .ext_drv_o (ext_drv_o),
  .xfer_drv_o(xfer_drv_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .maxerr_o  (maxerr_o),
  .count_o   (count_o),
  .max_cyc_i (max_cyc_i)
);

// File: tb/test_cts_sequencer.sv
module test_cts_sequencer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] ct_div_i = '0, ec_div_i = '0;
  logic [3:0] chg_len_i = '0, xfer_len_i = '0;
  logic       ec_en_i = 1'b0;
  logic [6:0] ec_max_i = '0;
  logic [7:0] max_cyc_i = '0;
  logic       vs_above_i = 1'b0;
  logic chg_drv_o, ext_drv_o, xfer_drv_o, busy_o, done_o, maxerr_o;
  logic [7:0] count_o;

  int vectors = 0;
  int fails = 0;

  typedef struct {
    bit vs, st, chg, ext, xfer, busy, done, merr;
    int cnt;
  } exp_t;
  exp_t q[$];
  int   last_cnt = 0;
  bit   last_merr = 0;

  always #2.5 clk_i = ~clk_i;

  cts_sequencer i_cts_sequencer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .ct_div_i(ct_div_i), .ec_div_i(ec_div_i),
    .chg_len_i(chg_len_i), .xfer_len_i(xfer_len_i),
    .ec_en_i(ec_en_i), .ec_max_i(ec_max_i), .max_cyc_i(max_cyc_i),
    .vs_above_i(vs_above_i),
    .chg_drv_o(chg_drv_o), .ext_drv_o(ext_drv_o), .xfer_drv_o(xfer_drv_o),
    .busy_o(busy_o), .done_o(done_o), .maxerr_o(maxerr_o), .count_o(count_o)
  );

  function automatic int prof(int n, int e);
    int p = (n - 1) % (2 * e + 2);
    return (p <= e + 1) ? p : 2 * e + 2 - p;
  endfunction

  task automatic push(int k, bit vs, bit chg, bit ext, bit xfer, bit busy, bit done, bit merr, int cnt);
    for (int i = 0; i < k; i++) begin
      exp_t e;
      e.vs = vs; e.st = 0; e.chg = chg; e.ext = ext; e.xfer = xfer;
      e.busy = busy; e.done = done; e.merr = merr; e.cnt = cnt;
      q.push_back(e);
    end
  endtask

  task automatic cmp1(bit act, bit exp, string req, string nm);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic check_now(exp_t e);
    vectors++;
    cmp1(chg_drv_o, e.chg, "R3", "chg_drv");
    cmp1(ext_drv_o, e.ext, "R5", "ext_drv");
    cmp1(xfer_drv_o, e.xfer, "R2", "xfer_drv");
    cmp1(busy_o, e.busy, "R1", "busy");
    cmp1(done_o, e.done, "R7", "done");
    cmp1(maxerr_o, e.merr, "R8", "maxerr");
    if (int'(count_o) !== e.cnt) begin
      fails++;
      $display("FAIL R7 count actual=%0d expected=%0d at %0t", count_o, e.cnt, $time);
    end
  endtask

  // Build the expected clock-by-clock trace of one acquisition.
  task automatic build(int c, int x, int ctd, int ecd, bit en, int e, int maxc, int kvs, int glitch);
    int n = 1;
    int cd = 1 << ctd;
    int ed = 1 << ecd;
    bit done = 0;
    q.delete();
    while (!done) begin
      bit hi = (n >= kvs);
      int l = prof(n, e);
      push(1, hi || (n == glitch), 1, 0, 0, 1, 0, 0, last_cnt);
      push((c + 1) * cd - 1, hi, 1, 0, 0, 1, 0, 0, last_cnt);
      push(2, hi, 0, 0, 0, 1, 0, 0, last_cnt);
      if (en && l > 0) push(l * ed, hi, 0, 1, 0, 1, 0, 0, last_cnt);
      push((x + 1) * cd, hi, 0, 0, 1, 1, 0, 0, last_cnt);
      push(2, hi, 0, 0, 0, 1, 0, 0, last_cnt);
      push(1, hi, 0, 0, 0, 1, 0, 0, last_cnt);
      if (hi || n >= maxc) begin
        last_cnt  = n;
        last_merr = !hi;
        push(1, 0, 0, 0, 0, 0, 1, last_merr, last_cnt);
        push(3, 0, 0, 0, 0, 0, 0, last_merr, last_cnt);
        done = 1;
      end else begin
        push(2, hi, 0, 0, 0, 1, 0, 0, last_cnt);
        n++;
      end
    end
  endtask

  task automatic run(int c, int x, int ctd, int ecd, bit en, int e, int maxc,
                     int kvs, int glitch, int busy_start_at);
    @(negedge clk_i);
    chg_len_i = 4'(c); xfer_len_i = 4'(x); ct_div_i = 3'(ctd); ec_div_i = 3'(ecd);
    ec_en_i = en; ec_max_i = 7'(e); max_cyc_i = 8'(maxc);
    build(c, x, ctd, ecd, en, e, maxc, kvs, glitch);
    start_i = 1'b1;
    vs_above_i = 1'b0;
    foreach (q[i]) begin
      @(negedge clk_i);
      check_now(q[i]);
      start_i = (i == busy_start_at);  // R10: start while busy must be ignored
      vs_above_i = q[i].vs;
    end
    start_i = 1'b0;
    vs_above_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    r.chg = 0; r.ext = 0; r.xfer = 0; r.busy = 0; r.done = 0; r.merr = 0; r.cnt = 0;
    check_now(r);  // R1 reset state
    // R5 bound 0, R8 limit end, R4 extend divider 2 with charge divider 1
    run(1, 0, 0, 1, 1, 0, 6, 1000, 0, -1);
    // R5 bound 1, R3 charge/transfer divider 2
    run(0, 2, 1, 0, 1, 1, 10, 1000, 0, -1);
    // R5 bound 5 over a full period and beyond
    run(2, 1, 0, 0, 1, 5, 14, 1000, 0, -1);
    // R7 comparator end, R9 glitch in cycle 2, R10 start while busy
    run(3, 1, 0, 1, 1, 2, 20, 4, 2, 3);
    // R6 extend disabled
    run(1, 1, 0, 0, 0, 3, 9, 3, 0, -1);
    // R8 max count 0 acts as 1, R3 divider 128, R6 zero length skipped
    run(0, 0, 7, 7, 1, 4, 0, 1000, 0, -1);
    // R8 comparator and limit in the same cycle: maxerr stays 0
    run(0, 0, 0, 0, 1, 1, 2, 2, 0, -1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule